// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer for a chip's peripheral bus. Software sets a timeout in half-second units and enables the timer. From then on it has to keep writing a two-word key pair to a service register. If the count reaches zero first, the block records that the reset came from a timeout and sends a one-cycle pulse to the system reset controller. A control write can also request a reset at once, as a software-initiated reset. Each such write records a software cause.

An optional early-warning interrupt is chosen by a parameter. It fires a programmable number of ticks before expiry. It is armed only if the count is still above that threshold when the timer is started. The enable bit and the interrupt settings become fixed after their first write, so runaway code cannot switch the protection off.

Registers are 16 bits wide. They sit at byte offsets 0x0 (control), 0x2 (service), 0x4 (reset cause), 0x6 (interrupt setup) and 0x8 (auxiliary). Read data appears one clock after the read request. The half-second tick is made by dividing the clock by `TICK_DIV`.

Top module: `wdt_top`

## Requirements
- R1: After reset the registers read as follows: control 0x0006, service 0x0000, reset cause 0x0000, interrupt setup 0x0004 (the `PT_DEF` default), auxiliary 0x0001. Both `irq_o` and `sys_rst_o` are low. Read data appears on the cycle after the read request.
- R2: Control bits 15:8 hold the timeout field N. A control write loads the counter with N+1 ticks, and a tick comes every `TICK_DIV` clocks. If the write is accepted on edge E, `sys_rst_o` is high for exactly one cycle starting after edge E+1+TICK_DIV*(N+1).
- R3: The counter runs only when the enable bit (control bit 0) is 1 and N is nonzero. Otherwise no expiry ever occurs.
- R4: A service write of 0x5555 followed directly by a service write of 0xAAAA reloads the count to N+1. Expiry then follows the R2 timing, counted from the second key write. Any other service value written between the two keys cancels the reload.
- R5: When the counter expires, the reset-cause register becomes 0x0002 (bit 1 = timeout, bit 0 cleared) and `sys_rst_o` pulses.
- R6: Once the enable bit reads 1, writing 0 to it has no effect.
- R7: A control write with bit 1 = 0 sets the reset cause to 0x0001 (software). Bit 1 of control always reads back as 1.
- R8: A control write pulses `sys_rst_o` after edge E+1 in either of two cases: bits 1 and 2 are both written 0, or the resulting enable is 1 with N = 0.
- R9: Interrupt setup bit 15 enables the early warning, and bits 7:0 hold the threshold P. The warning is armed at start only when N+1 > P. `irq_o` and status bit 14 then rise after the tick on which the count falls to P.
- R10: Writing 1 to interrupt setup bit 14 clears the status and drops `irq_o`. Bits 15 and 7:0 accept only the first write after reset.
- R11: The auxiliary register keeps only bit 0 of a write. Writes to the reset-cause register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after the read |
| irq_o | output | 1 | Early-warning interrupt, level |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
Expiry timing is measured for a range of random timeout values. Some runs get no service and some get a key pair at a random point. This separates the reload-from-key timing from the original start timing and catches off-by-one errors in the tick count. Directed cases cover the disabled and zero-timeout paths, a service sequence broken by a foreign value, and the software-reset encodings. Together these separate an immediate action from a timed expiry and a software cause from a timeout cause. Early-warning runs use a threshold below the start count and one above it, showing that arming depends on the start count. Lock tests write after the first write and read the register back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int DW = 16;   // register width
   localparam int TW = 8;    // timeout field width
   localparam int CW = TW + 1;

   // register select = byte offset >> 1
   localparam logic [2:0] SEL_CTL  = 3'd0;
   localparam logic [2:0] SEL_SVC  = 3'd1;
   localparam logic [2:0] SEL_CAUS = 3'd2;
   localparam logic [2:0] SEL_ICTL = 3'd3;
   localparam logic [2:0] SEL_AUX  = 3'd4;

   // control bits
   localparam int B_EN    = 0;
   localparam int B_SWRST = 1;   // 0 written = software reset request
   localparam int B_HOLD  = 2;   // with B_SWRST both 0 = immediate action
   localparam int B_TLO   = 8;

   // interrupt setup bits
   localparam int B_PIE = 15;
   localparam int B_STS = 14;

   // reset cause codes
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_SW   = 2'b01,
      CAUSE_TOUT = 2'b10
   } cause_e;
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
   parameter int unsigned TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

   logic [PW-1:0] pre_q;

   assign tick = run && (pre_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pre_q <= '0;
      else if (clr || !run || tick) pre_q <= '0;
      else                        pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown import wdt_pkg::*; #(
   parameter bit PT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic          reload,
   input  logic          rearm,
   input  logic          en,
   input  logic [TW-1:0] tmo,
   input  logic          pie,
   input  logic [TW-1:0] pv,
   output logic          run,
   output logic          expire,
   output logic          pre_hit
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] start_cnt;
   logic          start_run;
   logic          step;

   assign start_cnt = {1'b0, tmo} + CW'(1);
   assign start_run = en && (tmo != '0);
   assign step      = tick && !load && !reload;
   assign expire    = step && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run   <= 1'b0;
      end else if (load) begin
         run   <= start_run;
         cnt_q <= start_run ? start_cnt : '0;
      end else if (reload && run) begin
         cnt_q <= start_cnt;
      end else if (step) begin
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CW'(1)) run <= 1'b0;
      end
   end

   generate
      if (PT_EN) begin : g_pt
         logic armed_q;
         assign pre_hit = armed_q && step && ((cnt_q - CW'(1)) == {1'b0, pv});
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        armed_q <= 1'b0;
            else if (load)     armed_q <= pie && start_run && (start_cnt > {1'b0, pv});
            else if (rearm)    armed_q <= pie && run && (cnt_q > {1'b0, pv});
            else if (pre_hit)  armed_q <= 1'b0;
         end
      end else begin : g_no_pt
         logic unused_pt;
         assign unused_pt = ^{pie, pv, rearm};
         assign pre_hit   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile import wdt_pkg::*; #(
   parameter bit          PT_EN  = 1'b1,
   parameter int unsigned PT_DEF = 4,
   parameter logic [15:0] KEY1   = 16'h5555,
   parameter logic [15:0] KEY2   = 16'hAAAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_valid,
   input  logic          bus_write,
   input  logic [3:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          expire,
   input  logic          pre_hit,
   output logic          ctl_en,
   output logic [TW-1:0] ctl_tmo,
   output logic          ictl_pie,
   output logic [TW-1:0] ictl_pv,
   output logic          irq,
   output logic          start_q,
   output logic          svc_q,
   output logic          ictl_q,
   output logic          imm_q,
   output cause_e        cause_q
);
   logic [2:0]    sel;
   logic          wr, rd, odd;
   logic          wr_ctl, wr_svc, wr_ictl, wr_aux;
   logic [DW-1:0] ctl_reg, svc_reg, ctl_wv, rd_mux;
   logic          aux_q;
   logic          imm_req;
   logic          ictl_sts;

   assign sel     = bus_addr[3:1];
   assign odd     = bus_addr[0];
   assign wr      = bus_valid && bus_write && !odd;
   assign rd      = bus_valid && !bus_write;
   assign wr_ctl  = wr && (sel == SEL_CTL);
   assign wr_svc  = wr && (sel == SEL_SVC);
   assign wr_ictl = wr && (sel == SEL_ICTL);
   assign wr_aux  = wr && (sel == SEL_AUX);

   assign ctl_en  = ctl_reg[B_EN];
   assign ctl_tmo = ctl_reg[B_TLO +: TW];
   assign irq     = ictl_sts;

   // control write value after the sticky enable and the always-one bit
   always_comb begin
      ctl_wv          = bus_wdata;
      ctl_wv[B_SWRST] = 1'b1;
      if (ctl_reg[B_EN]) ctl_wv[B_EN] = 1'b1;
      imm_req = (!bus_wdata[B_HOLD] && !bus_wdata[B_SWRST]) ||
                (ctl_wv[B_EN] && (ctl_wv[B_TLO +: TW] == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_reg <= DW'((1 << B_SWRST) | (1 << B_HOLD));
         svc_reg <= '0;
         aux_q   <= 1'b1;
         cause_q <= CAUSE_NONE;
         start_q <= 1'b0;
         svc_q   <= 1'b0;
         imm_q   <= 1'b0;
      end else begin
         start_q <= wr_ctl;
         imm_q   <= wr_ctl && imm_req;
         svc_q   <= wr_svc && (svc_reg == KEY1) && (bus_wdata == KEY2);
         if (wr_ctl) ctl_reg <= ctl_wv;
         if (wr_svc) svc_reg <= bus_wdata;
         if (wr_aux) aux_q   <= bus_wdata[0];
         if (expire) cause_q <= CAUSE_TOUT;
         if (wr_ctl && !bus_wdata[B_SWRST]) cause_q <= CAUSE_SW;
      end
   end

   generate
      if (PT_EN) begin : g_ictl
         logic lock_q, pie_q, sts_q, req_q;
         logic [TW-1:0] pv_q;
         assign ictl_pie = pie_q;
         assign ictl_pv  = pv_q;
         assign ictl_sts = sts_q;
         assign ictl_q   = req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lock_q <= 1'b0;
               pie_q  <= 1'b0;
               sts_q  <= 1'b0;
               req_q  <= 1'b0;
               pv_q   <= TW'(PT_DEF);
            end else begin
               req_q <= wr_ictl;
               if (wr_ictl && !lock_q) begin
                  pie_q <= bus_wdata[B_PIE];
                  pv_q  <= bus_wdata[TW-1:0];
               end
               if (wr_ictl) lock_q <= 1'b1;
               if (wr_ictl && bus_wdata[B_STS]) sts_q <= 1'b0;
               else if (pre_hit)                sts_q <= 1'b1;
            end
         end
      end else begin : g_no_ictl
         logic unused_ictl;
         assign unused_ictl = ^{pre_hit, wr_ictl};
         assign ictl_pie = 1'b0;
         assign ictl_pv  = TW'(PT_DEF);
         assign ictl_sts = 1'b0;
         assign ictl_q   = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (!odd) begin
         case (sel)
            SEL_CTL:  rd_mux = ctl_reg;
            SEL_SVC:  rd_mux = svc_reg;
            SEL_CAUS: rd_mux = {{(DW-2){1'b0}}, cause_q};
            SEL_ICTL: rd_mux = {ictl_pie, ictl_sts, {(DW-2-TW){1'b0}}, ictl_pv};
            SEL_AUX:  rd_mux = {{(DW-1){1'b0}}, aux_q};
            default:  rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bus_rdata <= '0;
      else if (rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/wdt_top.sv
module wdt_top import wdt_pkg::*; #(
   parameter int unsigned TICK_DIV = 24_000_000,
   parameter bit          PT_EN    = 1'b1,
   parameter int unsigned PT_DEF   = 4,
   parameter logic [15:0] KEY1     = 16'h5555,
   parameter logic [15:0] KEY2     = 16'hAAAA
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_valid,
   input  logic        bus_write,
   input  logic [3:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        irq_o,
   output logic        sys_rst_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (PT_DEF >= (1 << TW)) begin : g_bad_pt
         $error("PT_DEF must fit the threshold field");
      end
      if (KEY1 == KEY2) begin : g_bad_key
         $error("service keys must differ");
      end
   endgenerate

   logic          ctl_en, ictl_pie;
   logic [TW-1:0] ctl_tmo, ictl_pv;
   logic          start_q, svc_q, ictl_q, imm_q;
   logic          cnt_run, tick, expire, pre_hit;
   cause_e        rst_cause;

   wdt_regfile #(.PT_EN(PT_EN), .PT_DEF(PT_DEF), .KEY1(KEY1), .KEY2(KEY2)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .expire(expire), .pre_hit(pre_hit),
      .ctl_en(ctl_en), .ctl_tmo(ctl_tmo), .ictl_pie(ictl_pie), .ictl_pv(ictl_pv),
      .irq(irq_o), .start_q(start_q), .svc_q(svc_q), .ictl_q(ictl_q),
      .imm_q(imm_q), .cause_q(rst_cause)
   );

   wdt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(cnt_run), .clr(start_q || svc_q), .tick(tick)
   );

   wdt_countdown #(.PT_EN(PT_EN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(start_q), .reload(svc_q), .rearm(ictl_q),
      .en(ctl_en), .tmo(ctl_tmo), .pie(ictl_pie), .pv(ictl_pv),
      .run(cnt_run), .expire(expire), .pre_hit(pre_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sys_rst_o <= 1'b0;
      else        sys_rst_o <= imm_q || expire;
   end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_valid,
   input logic        bus_write,
   input logic [3:0]  bus_addr,
   input logic [15:0] bus_wdata,
   input logic [15:0] bus_rdata,
   input logic        irq_o,
   input logic        ctl_en,
   input logic        cnt_run,
   input logic [1:0]  rst_cause
);
   p_en_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_en |=> ctl_en);

   p_idle_without_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> !cnt_run);

   p_sw_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == 4'h0 && !bus_wdata[1]) |=> (rst_cause == 2'b01));

   p_ctl_bit1_reads_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == 4'h0) |=> bus_rdata[1]);

   p_w1c_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == 4'h6 && bus_wdata[14]) |=> !irq_o);

   p_aux_one_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == 4'h8) |=> (bus_rdata[15:1] == 15'h0));
endmodule

bind wdt_top wdt_checker i_wdt_checker (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq_o(irq_o), .ctl_en(ctl_en), .cnt_run(cnt_run), .rst_cause(rst_cause)
);

// File: tb/test_wdt_top.sv
`timescale 1ns/1ps
module test_wdt_top;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o, sys_rst_o;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int t_wr;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_top #(.TICK_DIV(DIV), .PT_EN(1'b1), .PT_DEF(4)) i_wdt_top (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o)
   );

   function automatic int exp_at(int t, int ticks);
      return t + 2 + DIV * ticks;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      t_wr = cyc;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output int d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      d = int'(bus_rdata);
      bus_valid = 1'b0;
   endtask

   // which = 0: sys_rst_o, 1: irq_o; returns cycle seen or -1
   task automatic wait_for(int which, int limit, output int seen);
      int stop;
      stop = cyc + limit;
      seen = -1;
      while (cyc < stop) begin
         if ((which == 0 && sys_rst_o) || (which == 1 && irq_o)) begin
            seen = cyc;
            break;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v, seen, t0, tmo;
      void'($urandom(32'd2024));

      // R1: reset state
      do_reset();
      check("R1 irq", int'(irq_o), 0);
      check("R1 sys_rst", int'(sys_rst_o), 0);
      rd(4'h0, v); check("R1 control", v, 16'h0006);
      rd(4'h2, v); check("R1 service", v, 0);
      rd(4'h4, v); check("R1 cause", v, 0);
      rd(4'h6, v); check("R1 ictl", v, 16'h0004);
      rd(4'h8, v); check("R1 aux", v, 1);

      // R2/R5: plain expiry, N=3
      do_reset();
      wr(4'h0, 16'h0307); t0 = t_wr;
      wait_for(0, 200, seen);
      check("R2 expiry cycle", seen, exp_at(t0, 4));
      @(negedge clk);
      check("R5 pulse one cycle", int'(sys_rst_o), 0);
      rd(4'h4, v); check("R5 timeout cause", v, 2);
      wr(4'h4, 16'hFFFF);
      rd(4'h4, v); check("R11 cause write ignored", v, 2);
      rd(4'h0, v); check("R7 swrst reads one", v, 16'h0307);

      // R11: aux keeps bit 0 only
      wr(4'h8, 16'hFFFE); rd(4'h8, v); check("R11 aux clear", v, 0);
      wr(4'h8, 16'hFFFF); rd(4'h8, v); check("R11 aux set", v, 1);

      // R3: enable clear -> no expiry
      do_reset();
      wr(4'h0, 16'h0306);
      wait_for(0, 100, seen); check("R3 no run without enable", seen, -1);
      rd(4'h4, v); check("R3 cause untouched", v, 0);

      // R8: enable with zero timeout -> immediate, no later expiry
      do_reset();
      wr(4'h0, 16'h0007); t0 = t_wr;
      wait_for(0, 20, seen); check("R8 zero timeout action", seen, exp_at(t0, 0));
      @(negedge clk);
      wait_for(0, 100, seen); check("R3 zero timeout never runs", seen, -1);
      rd(4'h4, v); check("R8 no cause recorded", v, 0);

      // R8/R7: hold and swrst both zero
      do_reset();
      wr(4'h0, 16'h0000); t0 = t_wr;
      wait_for(0, 20, seen); check("R8 both zero action", seen, exp_at(t0, 0));
      rd(4'h4, v); check("R7 sw cause", v, 1);

      // R7: swrst zero, hold one -> cause only, no action
      do_reset();
      wr(4'h0, 16'h0804);
      wait_for(0, 60, seen); check("R7 no action with hold set", seen, -1);
      rd(4'h4, v); check("R7 sw cause only", v, 1);
      rd(4'h0, v); check("R7 control readback", v, 16'h0806);

      // R6: enable sticky
      do_reset();
      wr(4'h0, 16'h0A07);
      wr(4'h0, 16'h0A06);
      rd(4'h0, v); check("R6 enable stays set", v, 16'h0A07);

      // R4: broken sequence does not reload
      do_reset();
      wr(4'h0, 16'h0607); t0 = t_wr;
      repeat (4) @(negedge clk);
      wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
      wait_for(0, 200, seen); check("R4 broken sequence", seen, exp_at(t0, 7));

      // R9/R10: early warning armed
      do_reset();
      wr(4'h6, 16'h8002);
      wr(4'h0, 16'h0507); t0 = t_wr;
      wait_for(1, 200, seen); check("R9 irq cycle", seen, exp_at(t0, 4));
      rd(4'h6, v); check("R9 status bit", v, 16'hC002);
      wr(4'h6, 16'h4009);
      check("R10 w1c drops irq", int'(irq_o), 0);
      rd(4'h6, v); check("R10 fields locked", v, 16'h8002);

      // R9: threshold above start count -> never armed
      do_reset();
      wr(4'h6, 16'h800A);
      wr(4'h0, 16'h0307); t0 = t_wr;
      wait_for(0, 200, seen); check("R9 unarmed expiry", seen, exp_at(t0, 4));
      check("R9 no irq when unarmed", int'(irq_o), 0);

      // R4/R2: random timeouts with a service at a random point
      for (int i = 0; i < 8; i++) begin
         int d, t2;
         do_reset();
         tmo = 2 + int'($urandom % 15);
         wr(4'h0, 16'((tmo << 8) | 7)); t0 = t_wr;
         if (i % 3 == 0) begin
            wait_for(0, 2000, seen);
            check("R2 random expiry", seen, exp_at(t0, tmo + 1));
         end else begin
            d = int'($urandom % (DIV * tmo - 6));
            repeat (d) @(negedge clk);
            wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA); t2 = t_wr;
            wait_for(0, 2000, seen);
            check("R4 random service reload", seen, exp_at(t2, tmo + 1));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule